// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block walks the singly linked chain of extended capability headers that lives in a 4 KB configuration space. It owns no storage of its own. It reaches the space through a synchronous 32-bit read port, where data returns one cycle after the read enable, and through a 32-bit write port. One command is accepted at a time, and it is either a lookup or an append.

A lookup follows the chain from its fixed head. It returns the byte offset of the first header whose identifier matches, together with the offset of the header visited just before it. An append first runs a lookup in which matching is switched off, so the walk always ends at the tail. It then patches the tail's next-offset field to point at the new entry and writes the new header, whose next offset is zero. A malformed chain ends the command with an error code. The walk never leaves the legal window and always terminates.

The command port follows valid/ready rules. `cmd_ready` is high only while the engine is idle. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high, and the fields are captured on that edge. `cmd_ready` then stays low until the cycle after the one-cycle `done` strobe, so the source is held back for the whole command. Results are plain registered outputs that are valid while `done` is high and held until the next command finishes.

Top module: `xcap_chain_walker`

## Requirements
- R1: After reset `cmd_ready` is 1, and `done`, `rd_en` and `wr_en` are 0.
- R2: If the word at the list head (byte 256) reads as zero, the list is empty: a lookup returns match 0, previous 0, status 0 (ok).
- R3: A header is laid out as identifier in bits 15:0, version in bits 19:16 and next byte offset in bits 31:20. The low two bits of the next field are ignored, and a next value of 0 ends the chain.
- R4: A lookup stops at the first header whose identifier equals `cmd_id`. It returns that header's offset as match, the previously visited offset as previous (0 when the hit is at the head), and status 0.
- R5: A lookup that reaches the end of the chain without a hit returns match 0, previous equal to the last header's offset, and status 0.
- R6: A nonzero next offset below 256 or above 4088 stops the walk with status 1 (range), match 0 and previous 0. No read is ever issued outside that window.
- R7: When the STEP_LIMIT-th visited header still has a nonzero next, the walk stops with status 2 (loop) and match 0.
- R8: An append at offset O other than 256 on a non-empty list rewrites the tail word so that it becomes {O, tail bits 19:0}. It then writes {12'h000, version, identifier} at O and returns match O, previous = tail, status 0.
- R9: An append is refused with status 3 and no write when O is not 4-byte aligned, when O is below 256, when size is below 8, or when O + size exceeds 4096.
- R10: An append at 256 writes the header only when the list is empty, with previous 0. An append at 256 on a non-empty list, or at any other offset on an empty list, is refused with status 3 and no write.
- R11: After an accepted command `cmd_ready` stays low until `done`. Each command yields exactly one single-cycle `done` pulse, and the engine never reads and writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command accepted this edge if valid |
| cmd_append | input | 1 | 1 = append, 0 = lookup |
| cmd_id | input | 16 | Identifier to find or to write |
| cmd_ver | input | 4 | Version for an appended header |
| cmd_offset | input | 12 | Byte offset of the new entry (append) |
| cmd_size | input | 13 | Byte length of the new entry (append) |
| done | output | 1 | One-cycle completion strobe |
| res_match | output | 12 | Hit offset, or new entry offset on append |
| res_prev | output | 12 | Offset visited before the result |
| res_status | output | 2 | 0 ok, 1 range, 2 loop, 3 refused |
| rd_en | output | 1 | Read request |
| rd_addr | output | 10 | Word address of the read |
| rd_data | input | 32 | Read data, valid the cycle after rd_en |
| wr_en | output | 1 | Write request |
| wr_addr | output | 10 | Word address of the write |
| wr_data | output | 32 | Write data |

## Verification
The bench keeps the space at its full 4096 bytes, so both range edges (256 and 4088) and the last fitting append position (4080 with size 16) are exercised as they appear in use. It lowers STEP_LIMIT to 8. At that value a self-linked header reaches the loop guard within a few cycles, and a chain of exactly eight headers shows that a legal chain at the limit still ends normally.

// File: rtl/xcw_pkg.sv
package xcw_pkg;
  localparam int HDR_ID_LSB  = 0;
  localparam int HDR_ID_W    = 16;
  localparam int HDR_VER_LSB = 16;
  localparam int HDR_VER_W   = 4;
  localparam int HDR_NXT_LSB = 20;
  localparam int HDR_NXT_W   = 12;
  localparam int OFF_W       = HDR_NXT_W;

  typedef enum logic [1:0] {
    XS_OK      = 2'd0,
    XS_RANGE   = 2'd1,
    XS_LOOP    = 2'd2,
    XS_REFUSED = 2'd3
  } xcw_status_e;

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_WAIT, S_LINK, S_NEWHDR, S_FIN
  } xcw_state_e;

  function automatic logic [31:0] xcw_make_hdr(logic [HDR_ID_W-1:0] id,
                                              logic [HDR_VER_W-1:0] ver,
                                              logic [HDR_NXT_W-1:0] nxt);
    return {nxt, ver, id};
  endfunction
endpackage

// File: rtl/xcw_offset_range.sv
module xcw_offset_range #(
  parameter int SPACE_BYTES = 4096,
  parameter int LIST_BASE   = 256,
  parameter int OW          = 12
) (
  input  logic [OW-1:0] off,
  output logic          in_range
);
  localparam int HI_OFF = SPACE_BYTES - 8;
  assign in_range = (int'(off) >= LIST_BASE) && (int'(off) <= HI_OFF);
endmodule

// File: rtl/xcw_append_check.sv
module xcw_append_check #(
  parameter int SPACE_BYTES = 4096,
  parameter int LIST_BASE   = 256,
  parameter int OW          = 12
) (
  input  logic [OW-1:0] off,
  input  logic [OW:0]   size,
  output logic          ok
);
  localparam int MIN_SIZE = 8;
  logic aligned, above_base, big_enough, fits;
  assign aligned    = (off[1:0] == 2'b00);
  assign above_base = int'(off) >= LIST_BASE;
  assign big_enough = int'(size) >= MIN_SIZE;
  assign fits       = (int'(off) + int'(size)) <= SPACE_BYTES;
  assign ok = aligned && above_base && big_enough && fits;
endmodule

// File: rtl/xcw_step_guard.sv
module xcw_step_guard #(
  parameter int STEP_LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic last
);
  localparam int CW = $clog2(STEP_LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (bump)  cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CW'(STEP_LIMIT - 1));
endmodule

// File: rtl/xcap_chain_walker.sv
module xcap_chain_walker
  import xcw_pkg::*;
#(
  parameter int SPACE_BYTES = 4096,
  parameter int LIST_BASE   = 256,
  parameter int STEP_LIMIT  = 1024,
  localparam int WA_W       = $clog2(SPACE_BYTES) - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_append,
  input  logic [15:0]       cmd_id,
  input  logic [3:0]        cmd_ver,
  input  logic [OFF_W-1:0]  cmd_offset,
  input  logic [OFF_W:0]    cmd_size,
  output logic              done,
  output logic [OFF_W-1:0]  res_match,
  output logic [OFF_W-1:0]  res_prev,
  output logic [1:0]        res_status,
  output logic              rd_en,
  output logic [WA_W-1:0]   rd_addr,
  input  logic [31:0]       rd_data,
  output logic              wr_en,
  output logic [WA_W-1:0]   wr_addr,
  output logic [31:0]       wr_data
);
  localparam logic [OFF_W-1:0] BASE_OFF = OFF_W'(LIST_BASE);

  xcw_state_e st;
  logic              op_app;
  logic [15:0]       id_q;
  logic [3:0]        ver_q;
  logic [OFF_W-1:0]  off_q, cur, prev;
  logic [HDR_NXT_LSB-1:0] tail_low;

  logic              app_ok, nxt_ok, last_step;
  logic              is_empty, is_hit, is_end, app_at_base, advance;
  logic [OFF_W-1:0]  nxt_off;

  xcw_append_check #(.SPACE_BYTES(SPACE_BYTES), .LIST_BASE(LIST_BASE), .OW(OFF_W))
    u_app_chk (.off(cmd_offset), .size(cmd_size), .ok(app_ok));

  xcw_offset_range #(.SPACE_BYTES(SPACE_BYTES), .LIST_BASE(LIST_BASE), .OW(OFF_W))
    u_rng (.off(nxt_off), .in_range(nxt_ok));

  xcw_step_guard #(.STEP_LIMIT(STEP_LIMIT))
    u_guard (.clk(clk), .rst_n(rst_n), .clear(st == S_IDLE), .bump(advance), .last(last_step));

  // Header decode of the word returned for the current offset.
  always_comb begin
    nxt_off     = {rd_data[HDR_NXT_LSB + HDR_NXT_W - 1 : HDR_NXT_LSB + 2], 2'b00};
    is_empty    = (cur == BASE_OFF) && (rd_data == 32'h0);
    app_at_base = op_app && (off_q == BASE_OFF);
    is_hit      = !op_app && (rd_data[HDR_ID_LSB +: HDR_ID_W] == id_q);
    is_end      = (nxt_off == '0);
    advance     = (st == S_WAIT) && !is_empty && !app_at_base && !is_hit &&
                  !is_end && nxt_ok && !last_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      op_app     <= 1'b0;
      id_q       <= '0;
      ver_q      <= '0;
      off_q      <= '0;
      cur        <= '0;
      prev       <= '0;
      tail_low   <= '0;
      res_match  <= '0;
      res_prev   <= '0;
      res_status <= XS_OK;
    end else begin
      case (st)
        S_IDLE: if (cmd_valid) begin
          op_app <= cmd_append;
          id_q   <= cmd_id;
          ver_q  <= cmd_ver;
          off_q  <= cmd_offset;
          cur    <= BASE_OFF;
          prev   <= '0;
          if (cmd_append && !app_ok) begin
            res_match  <= '0;
            res_prev   <= '0;
            res_status <= XS_REFUSED;
            st         <= S_FIN;
          end else begin
            st <= S_READ;
          end
        end
        S_READ: st <= S_WAIT;
        S_WAIT: begin
          if (is_empty) begin
            res_match <= '0;
            res_prev  <= '0;
            if (app_at_base) begin
              st <= S_NEWHDR;
            end else begin
              res_status <= op_app ? XS_REFUSED : XS_OK;
              st         <= S_FIN;
            end
          end else if (app_at_base) begin
            res_match  <= '0;
            res_prev   <= '0;
            res_status <= XS_REFUSED;
            st         <= S_FIN;
          end else if (is_hit) begin
            res_match  <= cur;
            res_prev   <= prev;
            res_status <= XS_OK;
            st         <= S_FIN;
          end else if (is_end) begin
            res_match <= '0;
            res_prev  <= cur;
            if (op_app) begin
              tail_low <= rd_data[HDR_NXT_LSB-1:0];
              st       <= S_LINK;
            end else begin
              res_status <= XS_OK;
              st         <= S_FIN;
            end
          end else if (!nxt_ok) begin
            res_match  <= '0;
            res_prev   <= '0;
            res_status <= XS_RANGE;
            st         <= S_FIN;
          end else if (last_step) begin
            res_match  <= '0;
            res_prev   <= '0;
            res_status <= XS_LOOP;
            st         <= S_FIN;
          end else begin
            prev <= cur;
            cur  <= nxt_off;
            st   <= S_READ;
          end
        end
        S_LINK: st <= S_NEWHDR;
        S_NEWHDR: begin
          res_match  <= off_q;
          res_status <= XS_OK;
          st         <= S_FIN;
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready = (st == S_IDLE);
  assign done      = (st == S_FIN);
  assign rd_en     = (st == S_READ);
  assign rd_addr   = cur[WA_W+1:2];
  assign wr_en     = (st == S_LINK) || (st == S_NEWHDR);
  assign wr_addr   = (st == S_LINK) ? res_prev[WA_W+1:2] : off_q[WA_W+1:2];
  assign wr_data   = (st == S_LINK) ? {off_q, tail_low}
                                    : xcw_make_hdr(id_q, ver_q, '0);
endmodule

// File: rtl/xcw_checker.sv
module xcw_checker #(
  parameter int WA_W      = 10,
  parameter int LIST_BASE = 256
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic            done,
  input logic [11:0]     res_match,
  input logic [1:0]      res_status,
  input logic            rd_en,
  input logic [WA_W-1:0] rd_addr,
  input logic            wr_en,
  input logic [WA_W-1:0] wr_addr
);
  localparam logic [WA_W-1:0] BASE_WORD = WA_W'(LIST_BASE / 4);

  assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_rw_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));

  assert_write_only_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !cmd_ready);

  assert_read_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_addr >= BASE_WORD));

  assert_write_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr >= BASE_WORD));

  assert_error_no_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (res_status == 2'd1 || res_status == 2'd2)) |-> (res_match == 12'd0));
endmodule

bind xcap_chain_walker xcw_checker #(.WA_W(WA_W), .LIST_BASE(LIST_BASE)) u_xcw_checker (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .done(done), .res_match(res_match), .res_status(res_status),
  .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/test_xcap_chain_walker.sv
module test_xcap_chain_walker;
  localparam int WORDS = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_append = 1'b0;
  logic [15:0] cmd_id = '0;
  logic [3:0]  cmd_ver = '0;
  logic [11:0] cmd_offset = '0;
  logic [12:0] cmd_size = '0;
  logic        cmd_ready, done, rd_en, wr_en;
  logic [11:0] res_match, res_prev;
  logic [1:0]  res_status;
  logic [9:0]  rd_addr, wr_addr;
  logic [31:0] rd_data, wr_data;

  logic        tb_we = 1'b0;
  logic [9:0]  tb_addr = '0;
  logic [31:0] tb_data = '0;
  logic [31:0] mem [WORDS];

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [11:0] r_match, r_prev;
  logic [1:0]  r_status;

  always #5 clk = ~clk;

  xcap_chain_walker #(.STEP_LIMIT(8)) i_xcap_chain_walker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_append(cmd_append), .cmd_id(cmd_id), .cmd_ver(cmd_ver),
    .cmd_offset(cmd_offset), .cmd_size(cmd_size), .done(done),
    .res_match(res_match), .res_prev(res_prev), .res_status(res_status),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
    if (wr_en) mem[wr_addr] <= wr_data;
    else if (tb_we) mem[tb_addr] <= tb_data;
  end

  function automatic logic [31:0] hdr(logic [15:0] id, logic [3:0] ver, logic [11:0] nxt);
    return {nxt, ver, id};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic poke(int waddr, logic [31:0] d);
    tb_we = 1'b1; tb_addr = 10'(waddr); tb_data = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic clear_mem();
    for (int i = 64; i < WORDS; i++) poke(i, 32'h0);
  endtask

  task automatic run_cmd(logic app, logic [15:0] id, logic [3:0] ver,
                         logic [11:0] off, logic [12:0] size);
    int waited;
    cmd_valid = 1'b1; cmd_append = app; cmd_id = id; cmd_ver = ver;
    cmd_offset = off; cmd_size = size;
    @(negedge clk);
    cmd_valid = 1'b0;
    waited = 0;
    while (!done && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    if (!done) check("R11 done timeout", 0, 1);
    r_match = res_match; r_prev = res_prev; r_status = res_status;
    @(negedge clk);
  endtask

  task automatic build_list();
    clear_mem();
    poke(64,  hdr(16'h0001, 4'd1, 12'h140));
    poke(80,  hdr(16'h0010, 4'd2, 12'h202));   // low bits of next set: ignored (R3)
    poke(128, hdr(16'h0003, 4'd1, 12'h000));
  endtask

  // {id, expected match, expected previous, expected status}
  localparam logic [41:0] FIND_VEC [5] = '{
    {16'h0001, 12'h100, 12'h000, 2'd0},   // R4 hit at head
    {16'h0010, 12'h140, 12'h100, 2'd0},   // R4 middle
    {16'h0003, 12'h200, 12'h140, 2'd0},   // R4 tail via masked next, R3
    {16'h0099, 12'h000, 12'h200, 2'd0},   // R5 absent
    {16'h0000, 12'h000, 12'h200, 2'd0}    // R5 absent zero id
  };

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int done_cnt;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 cmd_ready", 32'(cmd_ready), 1);
    check("R1 done", 32'(done), 0);
    check("R1 rd_en", 32'(rd_en), 0);
    check("R1 wr_en", 32'(wr_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 64; i++) poke(i, 32'h0);

    build_list();
    for (int v = 0; v < 5; v++) begin
      run_cmd(1'b0, FIND_VEC[v][41:26], 4'd0, 12'h0, 13'h0);
      check("R4/R5 match", 32'(r_match), 32'(FIND_VEC[v][25:14]));
      check("R4/R5 prev", 32'(r_prev), 32'(FIND_VEC[v][13:2]));
      check("R4/R5 status", 32'(r_status), 32'(FIND_VEC[v][1:0]));
    end

    // R11 handshake and single done pulse
    cmd_valid = 1'b1; cmd_append = 1'b0; cmd_id = 16'h0003;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R11 ready low after accept", 32'(cmd_ready), 0);
    done_cnt = 0;
    for (int k = 0; k < 40; k++) begin
      if (done) done_cnt++;
      @(negedge clk);
    end
    check("R11 one done pulse", 32'(done_cnt), 1);
    check("R11 ready back", 32'(cmd_ready), 1);

    // R2 empty list
    clear_mem();
    run_cmd(1'b0, 16'h0001, 4'd0, 12'h0, 13'h0);
    check("R2 match", 32'(r_match), 0);
    check("R2 prev", 32'(r_prev), 0);
    check("R2 status", 32'(r_status), 0);

    // R10 append on empty list
    run_cmd(1'b1, 16'h0055, 4'd2, 12'h200, 13'd16);
    check("R10 nonbase on empty refused", 32'(r_status), 3);
    check("R10 nonbase no write", mem[128], 32'h0);
    run_cmd(1'b1, 16'h0055, 4'd2, 12'h100, 13'd16);
    check("R10 base on empty status", 32'(r_status), 0);
    check("R10 base match", 32'(r_match), 12'h100);
    check("R10 base prev", 32'(r_prev), 0);
    check("R10 base header", mem[64], hdr(16'h0055, 4'd2, 12'h0));
    run_cmd(1'b1, 16'h0066, 4'd1, 12'h100, 13'd16);
    check("R10 base on nonempty refused", 32'(r_status), 3);
    check("R10 base unchanged", mem[64], hdr(16'h0055, 4'd2, 12'h0));

    // R6 range errors: below the head and above 4088
    clear_mem();
    poke(64, hdr(16'h0001, 4'd1, 12'h010));
    run_cmd(1'b0, 16'h0007, 4'd0, 12'h0, 13'h0);
    check("R6 low status", 32'(r_status), 1);
    check("R6 low match", 32'(r_match), 0);
    poke(64, hdr(16'h0001, 4'd1, 12'hFFC));
    run_cmd(1'b0, 16'h0007, 4'd0, 12'h0, 13'h0);
    check("R6 high status", 32'(r_status), 1);
    poke(64, hdr(16'h0001, 4'd1, 12'hFF8));
    poke(1022, hdr(16'h0002, 4'd1, 12'h000));
    run_cmd(1'b0, 16'h0007, 4'd0, 12'h0, 13'h0);
    check("R6 edge 4088 legal status", 32'(r_status), 0);
    check("R6 edge 4088 prev", 32'(r_prev), 12'hFF8);

    // R7 self loop hits the step limit
    clear_mem();
    poke(64, hdr(16'h0001, 4'd1, 12'h100));
    run_cmd(1'b0, 16'h0007, 4'd0, 12'h0, 13'h0);
    check("R7 loop status", 32'(r_status), 2);
    check("R7 loop match", 32'(r_match), 0);

    // R7 chain of exactly STEP_LIMIT headers still ends normally
    clear_mem();
    for (int k = 0; k < 8; k++)
      poke(64 + 4 * k, hdr(16'h0001, 4'd1, (k == 7) ? 12'h0 : 12'(256 + 16 * (k + 1))));
    run_cmd(1'b0, 16'h0077, 4'd0, 12'h0, 13'h0);
    check("R7 limit chain status", 32'(r_status), 0);
    check("R7 limit chain prev", 32'(r_prev), 12'd368);

    // R8 append at the tail
    build_list();
    run_cmd(1'b1, 16'h00AA, 4'd3, 12'h300, 13'd16);
    check("R8 status", 32'(r_status), 0);
    check("R8 match", 32'(r_match), 12'h300);
    check("R8 prev", 32'(r_prev), 12'h200);
    check("R8 tail relinked", mem[128], hdr(16'h0003, 4'd1, 12'h300));
    check("R8 new header", mem[192], hdr(16'h00AA, 4'd3, 12'h0));
    run_cmd(1'b0, 16'h00AA, 4'd0, 12'h0, 13'h0);
    check("R8 found after append", 32'(r_match), 12'h300);
    check("R8 found prev", 32'(r_prev), 12'h200);

    // R9 refusals leave memory untouched
    run_cmd(1'b1, 16'h00BB, 4'd1, 12'h302, 13'd16);
    check("R9 misaligned", 32'(r_status), 3);
    check("R9 misaligned no write", mem[192], hdr(16'h00AA, 4'd3, 12'h0));
    run_cmd(1'b1, 16'h00BB, 4'd1, 12'h400, 13'd4);
    check("R9 too small", 32'(r_status), 3);
    run_cmd(1'b1, 16'h00BB, 4'd1, 12'hFF8, 13'd16);
    check("R9 does not fit", 32'(r_status), 3);
    run_cmd(1'b1, 16'h00BB, 4'd1, 12'h080, 13'd16);
    check("R9 below head", 32'(r_status), 3);
    check("R9 tail untouched", mem[192], hdr(16'h00AA, 4'd3, 12'h0));
    run_cmd(1'b1, 16'h00BB, 4'd1, 12'hFF0, 13'd16);
    check("R9 exact fit accepted", 32'(r_status), 0);
    check("R9 exact fit link", mem[192], hdr(16'h00AA, 4'd3, 12'hFF0));

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule